// File: doc/BRIEF.md
# Serial Controller Reset Sequencer

This block generates the internal reset lines of a two-channel serial communications controller. A reset arrives in one of two ways. The first is a hardware trigger: the bus holds the active-low write and read strobes low together, which a normal access never does. The second is a software command: an accepted write to the master control register whose top two bits select a reset scope. The block synchronises the strobes, works out the scope (whole device, channel A, channel B), and holds the matching reset outputs for a fixed stretch after the trigger goes away.

During a device-wide reset the block raises a bus-inhibit output, and any master control register write presented in that window is dropped. The six low bits of the master control register are held here. They change only on an accepted write or a hardware reset. A software command never clears them, so they can be written in the same access that issues the command. Channel resets leave the bus usable, so a second command can widen or extend a running channel reset.

Top module: `scc_reset_seq`

## Requirements
- R1: When both `wr_n` and `rd_n` are sampled low at rising edge k, `bus_block` is high after edge k+1, and `dev_rst`, `cha_rst` and `chb_rst` are all high after edge k+2.
- R2: All three reset outputs stay high for as long as both strobes keep being sampled low.
- R3: If edge m is the first edge that samples the strobes no longer both low, the resets and `bus_block` remain high through edge m+5 and are low after edge m+6.
- R4: The reset command is `mcr_wdata[7:6]`: 00 means no reset, 01 means channel B, 10 means channel A, 11 means full reset. An accepted command write at edge w raises its resets after edge w. They stay high through edge w+4 and drop after edge w+5.
- R5: A full software reset raises `dev_rst`, `cha_rst`, `chb_rst` and `bus_block` together. While `dev_rst` is high, both channel resets are high.
- R6: A channel command raises only that channel's reset. `dev_rst` and `bus_block` stay low.
- R7: An accepted write (`mcr_we` high while `bus_block` is low) loads `mcr_wdata[5:0]` into `mcr_bits`, including a write that carries a reset command. Software resets leave `mcr_bits` unchanged.
- R8: A hardware reset clears `mcr_bits` to zero after edge k+2.
- R9: A write presented while `bus_block` is high is ignored. It changes neither `mcr_bits` nor the reset outputs or their stretch.
- R10: A new trigger during an active stretch restarts the stretch from that trigger and adds its scope. A channel reset followed by the other channel's command holds both channels. A channel reset followed by a full command or a hardware reset widens to a full reset.
- R11: With `arst_n` low, all outputs are low immediately and `mcr_bits` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_n | input | 1 | Bus write strobe, active low, asynchronous |
| rd_n | input | 1 | Bus read strobe, active low, asynchronous |
| mcr_we | input | 1 | Write strobe for the master control register, one cycle |
| mcr_wdata | input | 8 | Write data; bits 7:6 carry the reset command |
| dev_rst | output | 1 | Device-wide reset |
| cha_rst | output | 1 | Channel A reset |
| chb_rst | output | 1 | Channel B reset |
| bus_block | output | 1 | Bus accesses are being ignored |
| mcr_bits | output | 6 | Non-command bits of the master control register |

## Verification
A table of command writes covers all four command codes with varied low bits. It separates correct scope decoding from swapped channel codes and confirms that the stored bits survive every software reset. A held pair of low strobes measures the assertion latency and the release stretch edge by edge, which exposes off-by-one stretch counts and a missing synchroniser stage. Overlapping triggers show whether scopes accumulate and the counter restarts: channel A then B, channel then full, channel then hardware. A write issued during a device reset shows whether the inhibit really drops data and commands.

// File: rtl/scc_reset_seq.sv
module scc_reset_seq #(
  parameter int STRETCH     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          mcr_we,
  input  logic [DW-1:0] mcr_wdata,
  output logic          dev_rst,
  output logic          cha_rst,
  output logic          chb_rst,
  output logic          bus_block,
  output logic [DW-3:0] mcr_bits
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam int QW = $clog2(STRETCH + 3);
  localparam logic [1:0] CMD_NONE = 2'b00;
  localparam logic [1:0] CMD_B    = 2'b01;
  localparam logic [1:0] CMD_A    = 2'b10;
  localparam logic [1:0] CMD_FULL = 2'b11;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   dev_q, a_q, b_q;
  logic [DW-3:0]          bits_q;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], ~(wr_n | rd_n)};

  wire       hw_hit = sync_q[SYNC_STAGES-1];
  wire [1:0] cmd    = mcr_wdata[DW-1:DW-2];
  wire       wr_ok  = mcr_we & ~bus_block;
  wire       sw_full = wr_ok & (cmd == CMD_FULL);
  wire       sw_a    = wr_ok & (cmd == CMD_A);
  wire       sw_b    = wr_ok & (cmd == CMD_B);
  wire       trig    = hw_hit | (wr_ok & (cmd != CMD_NONE));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      dev_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else if (trig) begin
      cnt_q <= CW'(STRETCH);
      dev_q <= dev_q | hw_hit | sw_full;
      a_q   <= a_q | hw_hit | sw_full | sw_a;
      b_q   <= b_q | hw_hit | sw_full | sw_b;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      dev_q <= 1'b0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)     bits_q <= '0;
    else if (hw_hit) bits_q <= '0;
    else if (wr_ok)  bits_q <= mcr_wdata[DW-3:0];

  assign dev_rst   = dev_q;
  assign cha_rst   = a_q;
  assign chb_rst   = b_q;
  assign bus_block = dev_q | hw_hit;
  assign mcr_bits  = bits_q;

  logic [QW-1:0] quiet_q;
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                      quiet_q <= '0;
    else if (trig)                    quiet_q <= '0;
    else if (quiet_q != QW'(STRETCH + 2)) quiet_q <= quiet_q + 1'b1;

  p_hw_scope_r1: assert property (@(posedge clk) disable iff (!arst_n)
    hw_hit |=> (dev_rst && cha_rst && chb_rst));
  p_stretch_len_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(cha_rst | chb_rst) |-> (quiet_q == QW'(STRETCH + 1)));
  p_sw_rise_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_ok && cmd != CMD_NONE) |=> (cha_rst || chb_rst));
  p_full_covers_r5: assert property (@(posedge clk) disable iff (!arst_n)
    dev_rst |-> (cha_rst && chb_rst && bus_block));
  p_chan_only_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (sw_b && !hw_hit && !dev_rst && !cha_rst) |=> (chb_rst && !cha_rst && !dev_rst));
  p_keep_bits_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (sw_full && !hw_hit) |=> (mcr_bits == $past(mcr_wdata[DW-3:0])));
  p_hw_clear_r8: assert property (@(posedge clk) disable iff (!arst_n)
    hw_hit |=> (mcr_bits == '0));
  p_block_drop_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (mcr_we && bus_block && !hw_hit) |=> $stable(mcr_bits));
endmodule

// File: tb/sim_scc_reset_seq.sv
module sim_scc_reset_seq;
  logic       clk = 1'b0;
  logic       arst_n, wr_n, rd_n, mcr_we;
  logic [7:0] mcr_wdata;
  logic       dev_rst, cha_rst, chb_rst, bus_block;
  logic [5:0] mcr_bits;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  scc_reset_seq u0 (
    .clk(clk), .arst_n(arst_n), .wr_n(wr_n), .rd_n(rd_n),
    .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
    .dev_rst(dev_rst), .cha_rst(cha_rst), .chb_rst(chb_rst),
    .bus_block(bus_block), .mcr_bits(mcr_bits)
  );

  // {wdata, dev, a, b}
  localparam logic [10:0] VEC [6] = '{
    {8'h05, 3'b000}, {8'h47, 3'b001}, {8'h8A, 3'b010},
    {8'hDB, 3'b111}, {8'h3C, 3'b000}, {8'hA5, 3'b010}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rst3(input string tag, input logic [2:0] exp);
    chk(tag, {5'b0, dev_rst, cha_rst, chb_rst}, {5'b0, exp});
  endtask

  task automatic wr(input logic [7:0] d);
    mcr_we = 1'b1; mcr_wdata = d;
    @(negedge clk);
    mcr_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    arst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; mcr_we = 1'b0; mcr_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst3("R11 reset outputs", 3'b000);
    chk("R11 reset block", {7'b0, bus_block}, 8'h00);
    chk("R11 reset bits", {2'b0, mcr_bits}, 8'h00);
    arst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][10:3]);
      rst3("R4 R5 R6 scope after write", VEC[i][2:0]);
      chk("R6 R5 block", {7'b0, bus_block}, {7'b0, VEC[i][2]});
      chk("R7 bits stored", {2'b0, mcr_bits}, {2'b0, VEC[i][8:3]});
      repeat (4) @(negedge clk);
      rst3("R4 held through w+4", VEC[i][2:0]);
      @(negedge clk);
      rst3("R4 low after w+5", 3'b000);
      chk("R7 bits kept", {2'b0, mcr_bits}, {2'b0, VEC[i][8:3]});
    end

    // hardware reset: R1 R2 R3 R8 R9
    wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    rst3("R1 not yet after k", 3'b000);
    @(negedge clk);
    chk("R1 block after k+1", {7'b0, bus_block}, 8'h01);
    rst3("R1 resets low after k+1", 3'b000);
    @(negedge clk);
    rst3("R1 resets after k+2", 3'b111);
    chk("R8 bits cleared", {2'b0, mcr_bits}, 8'h00);
    repeat (3) @(negedge clk);
    rst3("R2 held while low", 3'b111);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h3F);
    chk("R9 blocked write bits", {2'b0, mcr_bits}, 8'h00);
    repeat (3) @(negedge clk);
    rst3("R3 held through m+5", 3'b111);
    chk("R3 block through m+5", {7'b0, bus_block}, 8'h01);
    @(negedge clk);
    rst3("R3 low after m+6", 3'b000);
    chk("R3 block low after m+6", {7'b0, bus_block}, 8'h00);
    chk("R9 bits after stretch", {2'b0, mcr_bits}, 8'h00);

    // R10: A then B
    wr(8'h80);
    @(negedge clk);
    wr(8'h40);
    rst3("R10 both channels", 3'b011);
    chk("R10 block low on channels", {7'b0, bus_block}, 8'h00);
    repeat (4) @(negedge clk);
    rst3("R10 restarted stretch", 3'b011);
    @(negedge clk);
    rst3("R10 channels end", 3'b000);

    // R10: A then full, then a blocked write (R9)
    wr(8'h80);
    @(negedge clk);
    wr(8'hD5);
    rst3("R10 widened to full", 3'b111);
    chk("R7 bits with full cmd", {2'b0, mcr_bits}, 8'h15);
    wr(8'h6A);
    chk("R9 blocked bits", {2'b0, mcr_bits}, 8'h15);
    repeat (3) @(negedge clk);
    rst3("R10 full held w+4", 3'b111);
    @(negedge clk);
    rst3("R9 no restart from blocked cmd", 3'b000);
    chk("R7 bits after full", {2'b0, mcr_bits}, 8'h15);

    // R10: channel B then hardware
    wr(8'h40);
    rst3("R6 B only", 3'b001);
    wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rst3("R10 hw widens", 3'b111);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    rst3("R3 held after widen", 3'b111);
    @(negedge clk);
    rst3("R3 low after widen", 3'b000);
    chk("R8 bits after hw", {2'b0, mcr_bits}, 8'h00);

    // R11: async reset mid-stretch
    wr(8'hC9);
    rst3("R5 full before arst", 3'b111);
    #2 arst_n = 1'b0;
    #1;
    rst3("R11 async clears resets", 3'b000);
    chk("R11 async clears bits", {2'b0, mcr_bits}, 8'h00);
    chk("R11 async clears block", {7'b0, bus_block}, 8'h00);
    @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule